// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state updates a small 32-bit core needs when it enters an exception handler. The core presents a general exception request with a cause code, the faulting PC and, for address-related faults, the faulting virtual address. It can also present a debug request with its own cause. On a valid strobe the block decides which handler vector applies and updates the status word. It also loads the saved-PC, cause, faulting-address, debug-cause and saved-status registers that the handler later reads.

The status word is 8 bits wide. The interrupt level is in bits 3:0, the exception-mode flag is bit 4 and the user-mode flag is bit 5. A fault that arrives while the exception-mode flag is already set counts as a double exception. It goes to its own vector, and its PC can be kept in a dedicated register so that the first-level saved PC survives. A debug entry is gated by the interrupt level. When it is taken, it saves the whole status word and raises the interrupt level to the configured debug level.

The core also owns a plain status-load port, which it uses for example when returning from a handler. An entry in the same cycle takes precedence over that port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word is 0x1F (exception mode set, interrupt level 15, user mode clear). The vector select is 0 and every saved register is 0.
- R2: A taken entry produces a one-hot pulse on `vec_sel`, lasting exactly one cycle, on the clock edge that samples the strobe. The bit encoding is: bit 0 kernel, bit 1 user, bit 2 double, bit 3 debug. Without a taken entry `vec_sel` is 0.
- R3: A general exception selects double when the exception-mode flag is set. Otherwise it selects user when the user-mode flag is set, and kernel when that flag is clear.
- R4: A non-double general exception writes the PC to `epc1`. A double exception writes the PC to `depc` and leaves `epc1` unchanged when `HAS_DEPC`=1, and writes `epc1` when `HAS_DEPC`=0.
- R5: Every taken general exception writes its cause to `exc_cause_q` and sets the exception-mode flag. The user-mode flag and the interrupt level keep their values.
- R6: `fault_vaddr` is loaded with `exc_addr` only when `exc_has_addr` is set with the request. Otherwise it keeps its value.
- R7: A debug request is taken only when the current interrupt level is below `DEBUG_LEVEL`. A blocked debug request changes no register and produces no pulse.
- R8: A debug entry writes `dbg_cause_q` and writes the PC to `dbg_epc`. It copies the previous status word into `dbg_eps`, sets the interrupt level to `DEBUG_LEVEL` and sets the exception-mode flag. It leaves `epc1` and `exc_cause_q` unchanged.
- R9: A taken debug request wins over a simultaneous general request, which is then dropped. A blocked debug request lets a simultaneous general request proceed.
- R10: `ps_wr_en` loads `ps_wr_data` into the status word in a cycle with no taken entry. In a cycle with a taken entry the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | General exception request strobe |
| exc_cause | input | CAUSE_W | General exception cause code |
| req_pc | input | XLEN | PC of the faulting or debugged instruction |
| exc_has_addr | input | 1 | Request carries a faulting virtual address |
| exc_addr | input | XLEN | Faulting virtual address |
| dbg_valid | input | 1 | Debug request strobe |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| ps_wr_en | input | 1 | Status word load strobe |
| ps_wr_data | input | 8 | Status word load value |
| ps | output | 8 | Current status word |
| vec_sel | output | 4 | One-hot vector select pulse |
| epc1 | output | XLEN | Level-1 saved PC |
| depc | output | XLEN | Double-exception saved PC (0 when not configured) |
| exc_cause_q | output | CAUSE_W | Exception cause register |
| fault_vaddr | output | XLEN | Faulting virtual address register |
| dbg_cause_q | output | DCAUSE_W | Debug cause register |
| dbg_epc | output | XLEN | Saved PC for the debug level |
| dbg_eps | output | 8 | Saved status word for the debug level |

## Verification
The assertions check, on every cycle:
- that `vec_sel` is one-hot or zero;
- that a general request arriving with the exception-mode flag set selects double;
- that a blocked debug request alone leaves no pulse and the status word unchanged;
- that a debug entry sets the level and saves the previous status word;
- that a dropped general request leaves the cause untouched;
- that the status load works when no entry competes with it.

Only the bench's scenarios can show a few things:
- the actual PC, cause and address values that land in each register;
- the effect of the `HAS_DEPC` build choice, which the bench observes with a second instance;
- the order-dependent cases, where a status load changes the vector chosen by the next fault.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int PS_W        = 8;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam int VEC_W       = 4;
  localparam logic [PS_W-1:0] PS_RESET = 8'h1F;

  typedef enum logic [1:0] {
    VK_KERNEL = 2'd0,
    VK_USER   = 2'd1,
    VK_DOUBLE = 2'd2,
    VK_DEBUG  = 2'd3
  } vec_kind_e;

  function automatic logic [VEC_W-1:0] vec_onehot(vec_kind_e k);
    return VEC_W'(1) << k;
  endfunction

  function automatic logic [PS_LVL_W-1:0] ps_level(logic [PS_W-1:0] p);
    return p[PS_LVL_W-1:0];
  endfunction

  // General entry: only the exception-mode flag changes.
  function automatic logic [PS_W-1:0] ps_after_general(logic [PS_W-1:0] p);
    logic [PS_W-1:0] r;
    r = p;
    r[PS_EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // Debug entry: level replaced, exception-mode flag set.
  function automatic logic [PS_W-1:0] ps_after_debug(logic [PS_W-1:0] p,
                                                      logic [PS_LVL_W-1:0] lvl);
    logic [PS_W-1:0] r;
    r = p;
    r[PS_LVL_W-1:0] = lvl;
    r[PS_EXCM_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/exc_route.sv
module exc_route
  import exc_entry_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6
) (
  input  logic [PS_W-1:0] ps,
  input  logic            exc_valid,
  input  logic            dbg_valid,
  output logic            take_gen,
  output logic            take_dbg,
  output logic            is_double,
  output vec_kind_e       kind
);
  localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

  logic dbg_allowed;

  always_comb begin
    dbg_allowed = ps_level(ps) < DBG_LVL;
    take_dbg    = dbg_valid && dbg_allowed;
    take_gen    = exc_valid && !take_dbg;
    is_double   = ps[PS_EXCM_BIT];
    if (take_dbg)               kind = VK_DEBUG;
    else if (ps[PS_EXCM_BIT])   kind = VK_DOUBLE;
    else if (ps[PS_UM_BIT])     kind = VK_USER;
    else                        kind = VK_KERNEL;
  end

  // R9: a taken debug request always suppresses the general one
  always_comb begin
    if (take_dbg) assert (!take_gen) else $error("a_r9_dbg_excludes_gen");
  end

endmodule

// File: rtl/exc_savearea.sv
module exc_savearea
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_gen,
  input  logic                take_dbg,
  input  logic                is_double,
  input  logic [XLEN-1:0]     pc,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic                has_addr,
  input  logic [XLEN-1:0]     addr,
  input  logic [DCAUSE_W-1:0] dcause,
  input  logic [PS_W-1:0]     ps_old,
  output logic [XLEN-1:0]     epc1,
  output logic [XLEN-1:0]     depc,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [XLEN-1:0]     vaddr_q,
  output logic [DCAUSE_W-1:0] dcause_q,
  output logic [XLEN-1:0]     dbg_epc,
  output logic [PS_W-1:0]     dbg_eps
);
  logic epc1_we;
  logic depc_we;

  generate
    if (HAS_DEPC) begin : g_depc
      assign epc1_we = take_gen && !is_double;
      assign depc_we = take_gen && is_double;
      always_ff @(posedge clk) begin
        if (!rst_n)       depc <= '0;
        else if (depc_we) depc <= pc;
      end
      // R4: double fault keeps the level-1 saved PC
      a_r4_epc1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        depc_we |=> $stable(epc1));
    end else begin : g_no_depc
      assign epc1_we = take_gen;
      assign depc_we = 1'b0;
      assign depc    = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc1     <= '0;
      cause_q  <= '0;
      vaddr_q  <= '0;
      dcause_q <= '0;
      dbg_epc  <= '0;
      dbg_eps  <= '0;
    end else begin
      if (epc1_we)              epc1    <= pc;
      if (take_gen)             cause_q <= cause;
      if (take_gen && has_addr) vaddr_q <= addr;
      if (take_dbg) begin
        dcause_q <= dcause;
        dbg_epc  <= pc;
        dbg_eps  <= ps_old;
      end
    end
  end

  // R6: no address with the request leaves the faulting address alone
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take_gen && !has_addr) |=> $stable(vaddr_q));

  // R8: debug entry does not disturb the general cause
  a_r8_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> $stable(cause_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_valid,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic [XLEN-1:0]     req_pc,
  input  logic                exc_has_addr,
  input  logic [XLEN-1:0]     exc_addr,
  input  logic                dbg_valid,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic                ps_wr_en,
  input  logic [7:0]          ps_wr_data,
  output logic [7:0]          ps,
  output logic [3:0]          vec_sel,
  output logic [XLEN-1:0]     epc1,
  output logic [XLEN-1:0]     depc,
  output logic [CAUSE_W-1:0]  exc_cause_q,
  output logic [XLEN-1:0]     fault_vaddr,
  output logic [DCAUSE_W-1:0] dbg_cause_q,
  output logic [XLEN-1:0]     dbg_epc,
  output logic [7:0]          dbg_eps
);
  localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

  logic      take_gen;
  logic      take_dbg;
  logic      is_double;
  logic      entering;
  vec_kind_e kind;
  logic [PS_W-1:0] ps_next;

  exc_route #(.DEBUG_LEVEL(DEBUG_LEVEL)) u_route (
    .ps        (ps),
    .exc_valid (exc_valid),
    .dbg_valid (dbg_valid),
    .take_gen  (take_gen),
    .take_dbg  (take_dbg),
    .is_double (is_double),
    .kind      (kind)
  );

  exc_savearea #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .HAS_DEPC(HAS_DEPC)
  ) u_save (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_gen (take_gen),
    .take_dbg (take_dbg),
    .is_double(is_double),
    .pc       (req_pc),
    .cause    (exc_cause),
    .has_addr (exc_has_addr),
    .addr     (exc_addr),
    .dcause   (dbg_cause),
    .ps_old   (ps),
    .epc1     (epc1),
    .depc     (depc),
    .cause_q  (exc_cause_q),
    .vaddr_q  (fault_vaddr),
    .dcause_q (dbg_cause_q),
    .dbg_epc  (dbg_epc),
    .dbg_eps  (dbg_eps)
  );

  assign entering = take_gen || take_dbg;

  always_comb begin
    if (take_dbg)      ps_next = ps_after_debug(ps, DBG_LVL);
    else if (take_gen) ps_next = ps_after_general(ps);
    else if (ps_wr_en) ps_next = ps_wr_data;
    else               ps_next = ps;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps      <= PS_RESET;
      vec_sel <= '0;
    end else begin
      ps      <= ps_next;
      vec_sel <= entering ? vec_onehot(kind) : '0;
    end
  end

  // R2: vector select is never more than one-hot
  a_r2_vec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_sel));

  // R3: general request in exception mode goes to the double vector
  a_r3_double_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !dbg_valid && ps[PS_EXCM_BIT]) |=> (vec_sel == 4'b0100));

  // R5: general entry leaves the exception-mode flag set
  a_r5_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
    take_gen |=> ps[PS_EXCM_BIT]);

  // R7: blocked debug request alone changes nothing visible
  a_r7_dbg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && !exc_valid && !ps_wr_en && ps[PS_LVL_W-1:0] >= DBG_LVL)
      |=> (vec_sel == 4'b0000) && $stable(ps));

  // R8: debug entry raises the level and saves the old status
  a_r8_dbg_level: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (ps[PS_LVL_W-1:0] == DBG_LVL) && ps[PS_EXCM_BIT]
                 && (dbg_eps == $past(ps)) && (vec_sel == 4'b1000));

  // R10: status load takes effect when nothing competes
  a_r10_ps_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_wr_en && !exc_valid && !dbg_valid) |=> (ps == $past(ps_wr_data)));

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [5:0]  exc_cause = '0;
  logic [31:0] req_pc = '0;
  logic        exc_has_addr = 1'b0;
  logic [31:0] exc_addr = '0;
  logic        dbg_valid = 1'b0;
  logic [5:0]  dbg_cause = '0;
  logic        ps_wr_en = 1'b0;
  logic [7:0]  ps_wr_data = '0;

  logic [7:0]  ps, dbg_eps, ps1, dbg_eps1;
  logic [3:0]  vec_sel, vec_sel1;
  logic [31:0] epc1, depc, fault_vaddr, dbg_epc;
  logic [31:0] epc1_b, depc_b, fault_vaddr1, dbg_epc1;
  logic [5:0]  exc_cause_q, dbg_cause_q, exc_cause_q1, dbg_cause_q1;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.DEBUG_LEVEL(6), .HAS_DEPC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .req_pc(req_pc), .exc_has_addr(exc_has_addr), .exc_addr(exc_addr),
    .dbg_valid(dbg_valid), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
    .ps_wr_data(ps_wr_data), .ps(ps), .vec_sel(vec_sel), .epc1(epc1),
    .depc(depc), .exc_cause_q(exc_cause_q), .fault_vaddr(fault_vaddr),
    .dbg_cause_q(dbg_cause_q), .dbg_epc(dbg_epc), .dbg_eps(dbg_eps)
  );

  exc_entry_ctrl #(.DEBUG_LEVEL(6), .HAS_DEPC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .req_pc(req_pc), .exc_has_addr(exc_has_addr), .exc_addr(exc_addr),
    .dbg_valid(dbg_valid), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
    .ps_wr_data(ps_wr_data), .ps(ps1), .vec_sel(vec_sel1), .epc1(epc1_b),
    .depc(depc_b), .exc_cause_q(exc_cause_q1), .fault_vaddr(fault_vaddr1),
    .dbg_cause_q(dbg_cause_q1), .dbg_epc(dbg_epc1), .dbg_eps(dbg_eps1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One-cycle request; returns at the negedge after the sampling edge.
  task automatic pulse_req(input logic ev, input logic [5:0] c, input logic [31:0] pc,
                           input logic ha, input logic [31:0] a,
                           input logic dv, input logic [5:0] dc,
                           input logic we, input logic [7:0] wd);
    exc_valid = ev; exc_cause = c; req_pc = pc; exc_has_addr = ha; exc_addr = a;
    dbg_valid = dv; dbg_cause = dc; ps_wr_en = we; ps_wr_data = wd;
    @(negedge clk);
    exc_valid = 1'b0; dbg_valid = 1'b0; ps_wr_en = 1'b0; exc_has_addr = 1'b0;
  endtask

  task automatic load_ps(input logic [7:0] v);
    pulse_req(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, v);
    chk("R10", "status load", 32'(ps), 32'(v));
  endtask

  task automatic chk_pulse_gone(input string req);
    @(negedge clk);
    chk(req, "pulse width", 32'(vec_sel), 32'h0);
  endtask

  task automatic t_reset;
    chk("R1", "ps", 32'(ps), 32'h1F);
    chk("R1", "vec_sel", 32'(vec_sel), 32'h0);
    chk("R1", "epc1", epc1, 32'h0);
    chk("R1", "depc", depc, 32'h0);
    chk("R1", "fault_vaddr", fault_vaddr, 32'h0);
  endtask

  task automatic t_double;
    pulse_req(1'b1, 6'd9, 32'h0000_1000, 1'b1, 32'hDEAD_0000, 1'b0, '0, 1'b0, '0);
    chk("R3", "double vector", 32'(vec_sel), 32'h4);
    chk("R4", "depc on double", depc, 32'h0000_1000);
    chk("R4", "epc1 kept on double", epc1, 32'h0);
    chk("R4", "epc1 without depc", epc1_b, 32'h0000_1000);
    chk("R4", "depc absent", depc_b, 32'h0);
    chk("R5", "cause", 32'(exc_cause_q), 32'd9);
    chk_pulse_gone("R2");
  endtask

  task automatic t_kernel;
    load_ps(8'h00);
    pulse_req(1'b1, 6'd3, 32'h0000_2004, 1'b1, 32'h1234_5678, 1'b0, '0, 1'b0, '0);
    chk("R3", "kernel vector", 32'(vec_sel), 32'h1);
    chk("R4", "epc1 normal", epc1, 32'h0000_2004);
    chk("R4", "depc untouched", depc, 32'h0000_1000);
    chk("R5", "cause", 32'(exc_cause_q), 32'd3);
    chk("R5", "ps after kernel", 32'(ps), 32'h10);
    chk("R6", "fault addr loaded", fault_vaddr, 32'h1234_5678);
    chk_pulse_gone("R2");
  endtask

  task automatic t_user;
    load_ps(8'h23);
    pulse_req(1'b1, 6'd20, 32'h0000_3008, 1'b0, 32'hFFFF_FFFF, 1'b0, '0, 1'b0, '0);
    chk("R3", "user vector", 32'(vec_sel), 32'h2);
    chk("R5", "ps after user", 32'(ps), 32'h33);
    chk("R6", "fault addr kept", fault_vaddr, 32'h1234_5678);
    chk("R4", "epc1 user", epc1, 32'h0000_3008);
    chk_pulse_gone("R2");
  endtask

  task automatic t_debug;
    load_ps(8'h23);
    pulse_req(1'b0, '0, 32'h0000_4000, 1'b0, '0, 1'b1, 6'd5, 1'b0, '0);
    chk("R8", "debug vector", 32'(vec_sel), 32'h8);
    chk("R8", "ps after debug", 32'(ps), 32'h36);
    chk("R8", "dbg_eps", 32'(dbg_eps), 32'h23);
    chk("R8", "dbg_epc", dbg_epc, 32'h0000_4000);
    chk("R8", "dbg_cause", 32'(dbg_cause_q), 32'd5);
    chk("R8", "epc1 kept", epc1, 32'h0000_3008);
    chk("R8", "cause kept", 32'(exc_cause_q), 32'd20);
    chk_pulse_gone("R2");
  endtask

  task automatic t_dbg_blocked;
    // level is now 6, equal to the debug level
    pulse_req(1'b0, '0, 32'h0000_5000, 1'b0, '0, 1'b1, 6'd7, 1'b0, '0);
    chk("R7", "no pulse", 32'(vec_sel), 32'h0);
    chk("R7", "ps kept", 32'(ps), 32'h36);
    chk("R7", "dbg_cause kept", 32'(dbg_cause_q), 32'd5);
    chk("R7", "dbg_epc kept", dbg_epc, 32'h0000_4000);
  endtask

  task automatic t_priority;
    load_ps(8'h02);
    pulse_req(1'b1, 6'd11, 32'h0000_6000, 1'b1, 32'hAAAA_0000, 1'b1, 6'd1, 1'b0, '0);
    chk("R9", "debug wins", 32'(vec_sel), 32'h8);
    chk("R9", "general dropped cause", 32'(exc_cause_q), 32'd20);
    chk("R9", "general dropped addr", fault_vaddr, 32'h1234_5678);
    chk("R9", "ps", 32'(ps), 32'h16);
    load_ps(8'h07);
    pulse_req(1'b1, 6'd12, 32'h0000_7000, 1'b0, '0, 1'b1, 6'd2, 1'b0, '0);
    chk("R9", "blocked debug lets general in", 32'(vec_sel), 32'h1);
    chk("R9", "general cause", 32'(exc_cause_q), 32'd12);
    chk("R9", "debug cause kept", 32'(dbg_cause_q), 32'd1);
    chk_pulse_gone("R2");
  endtask

  task automatic t_load_vs_entry;
    // ps is 0x17 (exception mode): entry wins over the load
    pulse_req(1'b1, 6'd30, 32'h0000_8000, 1'b0, '0, 1'b0, '0, 1'b1, 8'h00);
    chk("R10", "load ignored", 32'(ps), 32'h17);
    chk("R3", "double vector", 32'(vec_sel), 32'h4);
    chk("R4", "depc", depc, 32'h0000_8000);
    chk("R4", "epc1 kept", epc1, 32'h0000_7000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_double();
    t_kernel();
    t_user();
    t_debug();
    t_dbg_blocked();
    t_priority();
    t_load_vs_entry();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule